// File: doc/BRIEF.md
# Adaptive EPROM Programming Sequencer

This block writes a block of bytes into an ultraviolet-erasable PROM-style target. It programs the bytes one address at a time, starting at address zero and counting up. Each address first gets fixed one-millisecond program pulses on its active-low chip enable. After every pulse the block reads the byte back and compares it with the source. It counts the pulses the byte needed. When the byte reads back correctly, it applies one longer over-program pulse whose length is that count times a fixed multiple of a millisecond. Then it moves on to the next address with the count back at one.

While programming, the block asks the board for a raised supply rail and a high program voltage. It keeps the address and data valid for a setup interval before every pulse and holds them for a hold interval after it. After the last address it drops both rail requests and reads every byte back in normal read mode. A byte that gives up after too many pulses, or that miscompares in the final pass, ends the run with a fail flag and the failing address. All intervals are counted in clock cycles from a cycles-per-microsecond parameter, and one down-counter times all of them.

Top module: `eprom_burn_seq`

## Requirements
- R1: Out of reset and whenever idle, chip enable and output enable are high, both rail requests are low, the data bus is not driven, and done and fail are low.
- R2: Before every program pulse, both rail requests are high. The address, the data and the data-drive enable are also stable with drive on for at least SETUP_US×CYC_PER_US cycles before chip enable falls.
- R3: Every initial program pulse holds chip enable low for exactly US_PER_MS×CYC_PER_US cycles (one millisecond).
- R4: After each pulse, chip enable returns high and the address and data stay driven for at least HOLD_US×CYC_PER_US cycles. The verify read then releases the bus and pulls output enable low with chip enable high. The read data is valid only after SETTLE_US×CYC_PER_US cycles with output enable low, and only then may it be sampled.
- R5: A failed verify gives another initial pulse at the same address. If the verify after the MAX_TRY-th initial pulse still fails, the run ends with done and fail, fail_addr_o set to that address, and no over-program pulse.
- R6: When the verify after pulse n passes, exactly one over-program pulse follows at that address, with chip enable low for OVP_MULT×n×US_PER_MS×CYC_PER_US cycles. The next address starts again from one initial pulse.
- R7: Addresses are programmed in ascending order from 0 to 2^ADDR_W−1. The data driven at each address is the source byte read at that same address.
- R8: After the last address, both rail requests drop. Every address is read in ascending order with chip enable and output enable both low. If all of them match the source, done pulses with fail low.
- R9: A miscompare in the final read pass ends the run at once with done and fail, and fail_addr_o holds the miscomparing address.
- R10: done_o is high for exactly one cycle per run. fail_o and fail_addr_o hold until the next start, and start_i is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a run when idle |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Run ended in failure; held until next start |
| fail_addr_o | output | ADDR_W | Address at which the run failed |
| src_addr_o | output | ADDR_W | Source read address |
| src_data_i | input | DATA_W | Source byte for src_addr_o (combinational read) |
| tgt_addr_o | output | ADDR_W | Target address |
| tgt_data_o | output | DATA_W | Data to program (zero when not driven) |
| tgt_drive_o | output | 1 | Drive enable for the target data bus |
| tgt_ce_n_o | output | 1 | Target chip enable, active low |
| tgt_oe_n_o | output | 1 | Target output enable, active low |
| tgt_q_i | input | DATA_W | Data read from the target |
| vpp_hi_o | output | 1 | Request for the high program voltage |
| vcc_hi_o | output | 1 | Request for the raised supply level |

## Verification
A bad retry count shows up at the very next address. The over-program pulse comes out at the wrong length, or the next byte starts with too few pulses, so the first chip-enable width after the bad verify is wrong. A timer that reloads wrongly shows within one interval as a pulse, setup or hold window measured in cycles that misses its target. A stuck address or compare path shows by the end of the run as a wrong pulse order, a wrong fail address or the wrong number of final-pass reads. The bench model returns garbage until output enable has been low for the settle time, so a verify sampled too early turns into extra pulses at once.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY,
        ST_RAIL,
        ST_CMP,
        ST_END
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic drive;
        logic rails_hi;
    } tgt_ctl_t;

    // Target pin levels that each state presents
    function automatic tgt_ctl_t ctl_for(seq_state_t s);
        tgt_ctl_t c;
        c = '{ce_n: 1'b1, oe_n: 1'b1, drive: 1'b0, rails_hi: 1'b0};
        case (s)
            ST_SETUP, ST_HOLD: begin
                c.drive    = 1'b1;
                c.rails_hi = 1'b1;
            end
            ST_PULSE: begin
                c.ce_n     = 1'b0;
                c.drive    = 1'b1;
                c.rails_hi = 1'b1;
            end
            ST_VERIFY: begin
                c.oe_n     = 1'b0;
                c.rails_hi = 1'b1;
            end
            ST_CMP: begin
                c.ce_n = 1'b0;
                c.oe_n = 1'b0;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);

    // R3
    timer_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));

    // R3
    timer_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/try_counter.sv
module try_counter #(
    parameter int MAX_TRY = 25,
    parameter int NW      = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          inc_i,
    output logic [NW-1:0] n_o,
    output logic          last_o
);
    logic [NW-1:0] n_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            n_q <= NW'(1);
        else if (inc_i)
            n_q <= n_q + NW'(1);
    end

    assign n_o    = n_q;
    assign last_o = (n_q == NW'(MAX_TRY));

    // R5
    try_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (n_q >= NW'(1)) && (n_q <= NW'(MAX_TRY)));

    // R5
    no_inc_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> !last_o);

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int CYC_PER_US = 50,
    parameter int US_PER_MS  = 1000,
    parameter int MAX_TRY    = 25,
    parameter int OVP_MULT   = 3,
    parameter int SETUP_US   = 2,
    parameter int HOLD_US    = 2,
    parameter int SETTLE_US  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [DATA_W-1:0] tgt_data_o,
    output logic              tgt_drive_o,
    output logic              tgt_ce_n_o,
    output logic              tgt_oe_n_o,
    input  logic [DATA_W-1:0] tgt_q_i,
    output logic              vpp_hi_o,
    output logic              vcc_hi_o
);
    localparam int CYC_MS     = CYC_PER_US * US_PER_MS;
    localparam int PULSE_CYC  = CYC_MS;
    localparam int OVP_UNIT   = OVP_MULT * CYC_MS;
    localparam int SETUP_CYC  = SETUP_US * CYC_PER_US;
    localparam int HOLD_CYC   = HOLD_US * CYC_PER_US;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int MAX_CYC    = OVP_UNIT * MAX_TRY;
    localparam int TW         = $clog2(MAX_CYC + 1);
    localparam int NW         = $clog2(MAX_TRY + 1);

    seq_state_t state_q, state_d;
    tgt_ctl_t   ctl;

    logic [ADDR_W-1:0] addr_q, fail_addr_q;
    logic              ovp_q, fail_q;
    logic              last_addr, match;

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val, ovp_len;
    logic          n_clr, n_inc, n_last;
    logic [NW-1:0] n_val;
    logic          addr_clr, addr_inc, ovp_set, ovp_clr, fail_set, run_go;

    seq_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    try_counter #(.MAX_TRY(MAX_TRY), .NW(NW)) u_tries (
        .clk     (clk),
        .rst     (rst),
        .clear_i (n_clr),
        .inc_i   (n_inc),
        .n_o     (n_val),
        .last_o  (n_last)
    );

    assign last_addr = (addr_q == {ADDR_W{1'b1}});
    assign match     = (tgt_q_i == src_data_i);
    assign ovp_len   = TW'(n_val) * TW'(OVP_UNIT) - TW'(1);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        n_clr    = 1'b0;
        n_inc    = 1'b0;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        ovp_set  = 1'b0;
        ovp_clr  = 1'b0;
        fail_set = 1'b0;
        run_go   = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETUP_CYC - 1);
                n_clr    = 1'b1;
                addr_clr = 1'b1;
                ovp_clr  = 1'b1;
                run_go   = 1'b1;
            end
            ST_SETUP: if (tmr_zero) begin
                state_d  = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = ovp_q ? ovp_len : TW'(PULSE_CYC - 1);
            end
            ST_PULSE: if (tmr_zero) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (!ovp_q) begin
                    state_d = ST_VERIFY;
                    tmr_val = TW'(SETTLE_CYC - 1);
                end else if (last_addr) begin
                    state_d  = ST_RAIL;
                    tmr_val  = TW'(SETUP_CYC - 1);
                    addr_clr = 1'b1;
                end else begin
                    state_d  = ST_SETUP;
                    tmr_val  = TW'(SETUP_CYC - 1);
                    addr_inc = 1'b1;
                    n_clr    = 1'b1;
                    ovp_clr  = 1'b1;
                end
            end
            ST_VERIFY: if (tmr_zero) begin
                if (match) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                    ovp_set  = 1'b1;
                end else if (n_last) begin
                    state_d  = ST_END;
                    fail_set = 1'b1;
                end else begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                    n_inc    = 1'b1;
                end
            end
            ST_RAIL: if (tmr_zero) begin
                state_d  = ST_CMP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC - 1);
            end
            ST_CMP: if (tmr_zero) begin
                if (!match) begin
                    state_d  = ST_END;
                    fail_set = 1'b1;
                end else if (last_addr) begin
                    state_d = ST_END;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_CYC - 1);
                    addr_inc = 1'b1;
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            ovp_q       <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (addr_clr)
                addr_q <= '0;
            else if (addr_inc)
                addr_q <= addr_q + ADDR_W'(1);
            if (ovp_clr)
                ovp_q <= 1'b0;
            else if (ovp_set)
                ovp_q <= 1'b1;
            if (run_go) begin
                fail_q      <= 1'b0;
                fail_addr_q <= '0;
            end else if (fail_set) begin
                fail_q      <= 1'b1;
                fail_addr_q <= addr_q;
            end
        end
    end

    assign ctl         = ctl_for(state_q);
    assign done_o      = (state_q == ST_END);
    assign fail_o      = fail_q;
    assign fail_addr_o = fail_addr_q;
    assign src_addr_o  = addr_q;
    assign tgt_addr_o  = addr_q;
    assign tgt_data_o  = ctl.drive ? src_data_i : '0;
    assign tgt_drive_o = ctl.drive;
    assign tgt_ce_n_o  = ctl.ce_n;
    assign tgt_oe_n_o  = ctl.oe_n;
    assign vpp_hi_o    = ctl.rails_hi;
    assign vcc_hi_o    = ctl.rails_hi;

    // R4
    prog_bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        vpp_hi_o |-> (tgt_ce_n_o || tgt_oe_n_o));

    // R4
    drive_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!tgt_ce_n_o && vpp_hi_o) |-> tgt_drive_o);

    // R2
    rails_before_ce_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(tgt_ce_n_o) && tgt_oe_n_o) |-> (vpp_hi_o && vcc_hi_o && $past(vpp_hi_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    rails_low_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!vpp_hi_o && !vcc_hi_o && tgt_ce_n_o));

    // R9
    fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> done_o);

endmodule

// File: tb/eprom_burn_seq_tb.sv
module eprom_burn_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 3;
    localparam int DW   = 8;
    localparam int NB   = 1 << AW;
    localparam int CPU  = 2;
    localparam int UPM  = 10;
    localparam int MAXT = 25;
    localparam int MS   = CPU * UPM;
    localparam int SETUP_CYC  = 2 * CPU;
    localparam int HOLD_CYC   = 2 * CPU;
    localparam int SETTLE_CYC = 1 * CPU;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done, fail, drv, ce_n, oe_n, vpp, vcc;
    logic [AW-1:0] fail_addr, src_addr, taddr;
    logic [DW-1:0] src_data, tdata;
    logic [DW-1:0] q_in = '0;

    logic [DW-1:0] src_mem [NB];
    logic [DW-1:0] wr_data [NB];
    int need [NB];
    int pcnt [NB];
    bit corrupt_en = 0;
    int corrupt_addr = 0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int addr;
        int width;
        bit ovp;
    } pulse_t;
    pulse_t exp_q [$];

    assign src_data = src_mem[src_addr];

    always #(CLK_PERIOD / 2) clk = ~clk;

    eprom_burn_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CYC_PER_US(CPU), .US_PER_MS(UPM),
        .MAX_TRY(MAXT), .OVP_MULT(3), .SETUP_US(2), .HOLD_US(2), .SETTLE_US(1)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .done_o(done), .fail_o(fail),
        .fail_addr_o(fail_addr), .src_addr_o(src_addr), .src_data_i(src_data),
        .tgt_addr_o(taddr), .tgt_data_o(tdata), .tgt_drive_o(drv),
        .tgt_ce_n_o(ce_n), .tgt_oe_n_o(oe_n), .tgt_q_i(q_in),
        .vpp_hi_o(vpp), .vcc_hi_o(vcc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Target model and monitor, evaluated away from the active edge
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    logic p_drv = 0, p_ce = 1, p_oe = 1;
    int stable_cnt = 0, since_rise = 0, ce_w = 0, oe_cnt = 0, cmp_reads = 0;
    bit rise_flag = 0;

    always @(negedge clk) begin
        logic [DW-1:0] rv;
        if (rst) begin
            p_ce = 1; p_oe = 1; p_drv = 0; stable_cnt = 0; rise_flag = 0;
        end else begin
            since_rise++;
            if (taddr != p_addr || tdata != p_data || drv != p_drv) begin
                if (rise_flag && p_drv)
                    chk(since_rise >= HOLD_CYC, "R4", "hold after pulse", since_rise, HOLD_CYC);
                rise_flag = 0;
                stable_cnt = 0;
            end else if (drv) begin
                stable_cnt++;
            end
            if (p_ce && !ce_n && oe_n) begin
                chk(stable_cnt >= SETUP_CYC, "R2", "setup before pulse", stable_cnt, SETUP_CYC);
                chk(vpp && vcc, "R2", "rails high at pulse", int'(vpp & vcc), 1);
                wr_data[taddr] = tdata;
                ce_w = 0;
            end
            if (!ce_n) ce_w++;
            if (!p_ce && ce_n && vpp) begin
                pcnt[taddr]++;
                since_rise = 0;
                rise_flag = 1;
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected pulse at addr", int'(taddr), -1);
                end else begin
                    pulse_t e;
                    e = exp_q.pop_front();
                    chk(int'(taddr) == e.addr, "R7", "pulse address", int'(taddr), e.addr);
                    if (e.ovp)
                        chk(ce_w == e.width, "R6", "over-program width", ce_w, e.width);
                    else
                        chk(ce_w == e.width, "R3", "initial pulse width", ce_w, e.width);
                end
            end
            if (p_oe && !oe_n && vpp)
                chk(ce_n && !drv, "R4", "verify with CE high and bus released",
                    int'(ce_n & ~drv), 1);
            if (oe_n) oe_cnt = 0;
            else if (p_oe || taddr != p_addr) oe_cnt = 1;
            else oe_cnt++;
            if (!vpp && !ce_n && !oe_n && oe_cnt == SETTLE_CYC) begin
                chk(int'(taddr) == cmp_reads, "R8", "compare order", int'(taddr), cmp_reads);
                cmp_reads++;
            end
            rv = (pcnt[taddr] >= need[taddr]) ? wr_data[taddr] : 8'hFF;
            if (!vpp && corrupt_en && int'(taddr) == corrupt_addr) rv = rv ^ 8'h10;
            q_in = (oe_cnt >= SETTLE_CYC) ? rv : ~rv;
            p_addr = taddr; p_data = tdata; p_drv = drv; p_ce = ce_n; p_oe = oe_n;
        end
    end

    // Driver: erase model, plan the expected pulse list, launch and wait
    task automatic run(input int exp_fail, input int exp_faddr, input int exp_reads,
                       input bit poke_busy);
        for (int a = 0; a < NB; a++) begin
            pcnt[a] = 0;
            wr_data[a] = 8'hFF;
        end
        cmp_reads = 0;
        exp_q.delete();
        for (int a = 0; a < NB; a++) begin
            if (need[a] > MAXT) begin
                for (int k = 0; k < MAXT; k++) exp_q.push_back('{a, MS, 1'b0});
                break;
            end
            for (int k = 0; k < need[a]; k++) exp_q.push_back('{a, MS, 1'b0});
            exp_q.push_back('{a, 3 * need[a] * MS, 1'b1});
        end
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke_busy) begin
            repeat (60) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        chk(int'(fail) == exp_fail, exp_fail ? "R9" : "R8", "fail flag", int'(fail), exp_fail);
        if (exp_fail)
            chk(int'(fail_addr) == exp_faddr, "R5", "fail address", int'(fail_addr), exp_faddr);
        chk(exp_q.size() == 0, "R6", "pulses left unissued", exp_q.size(), 0);
        chk(cmp_reads == exp_reads, "R8", "final-pass reads", cmp_reads, exp_reads);
        @(negedge clk);
        chk(!done, "R10", "done lasts one cycle", int'(done), 0);
        chk(int'(fail) == exp_fail, "R10", "fail held", int'(fail), exp_fail);
        chk(ce_n && oe_n && !vpp && !vcc && !drv, "R1", "idle pins after run",
            int'({ce_n, oe_n, vpp, vcc, drv}), 5'b11000);
        repeat (5) @(negedge clk);
        chk(!done, "R10", "no restart after run", int'(done), 0);
    endtask

    initial begin
        for (int a = 0; a < NB; a++) begin
            src_mem[a] = DW'(a * 37 + 5);
            need[a] = 1;
            pcnt[a] = 0;
            wr_data[a] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ce_n && oe_n && !vpp && !vcc && !drv && !done && !fail, "R1", "reset pins",
            int'({ce_n, oe_n, vpp, vcc, drv, done, fail}), 7'b1100000);

        // Mixed pulse counts, including the retry limit reached exactly; busy start
        need[0] = 1; need[1] = 3; need[2] = 1; need[3] = 25;
        need[4] = 2; need[5] = 1; need[6] = 4; need[7] = 1;
        run(0, 0, NB, 1'b1);

        // Retry exhaustion at address 2 (R5)
        for (int a = 0; a < NB; a++) need[a] = 1;
        need[2] = 26;
        run(1, 2, 0, 1'b0);

        // Final-pass miscompare at address 5 with fresh data (R9)
        for (int a = 0; a < NB; a++) begin
            need[a] = 1;
            src_mem[a] = DW'(8'h80 | a);
        end
        corrupt_en = 1; corrupt_addr = 5;
        run(1, 5, 6, 1'b0);

        // Clean run after a failure clears the fail state (R10)
        corrupt_en = 0;
        need[0] = 2; need[7] = 5;
        run(0, 0, NB, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule